// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver

This block takes in one byte at a time over a clock-synchronous serial link. It works either as the clock master, making the serial clock from the system clock through a programmable divider and driving it out, or as a clock slave, following a clock that comes from outside. Serial data is shifted into an 8-bit register, MSB first, on rising edges of the serial clock. When the byte is complete it is copied into a receive buffer, and a sticky completion flag is raised. That flag can also raise an interrupt request.

Software first sets the receive enable, which only arms the receiver. It then starts every byte with its own one-cycle trigger pulse. The byte finishes on the sixteenth serial clock edge after the trigger. With the clock idling low (`pol_neg` = 0) this is the 8th falling edge. With the clock idling high (`pol_neg` = 1) it is the 8th rising edge. Clearing the receive enable stops any byte in flight and returns the block to idle.

Top module: `sync_rx`

## Requirements
- R1: When `rx_en` is 0, `busy` is 0 from the next clock edge. Any byte in flight is dropped without setting `done`, and in master mode `sclk_out` goes back to its idle level.
- R2: A `trig` pulse while `rx_en` is 0 is ignored. While armed but not triggered, no serial clock is driven and nothing is captured.
- R3: A `trig` pulse while `rx_en` is 1 and `busy` is 0 sets `busy` at the next clock edge. `busy` stays 1 until the byte completes.
- R4: In master mode `sclk_oe` is 1 and `sclk_out` idles at the level of `pol_neg`. After a trigger, `sclk_out` toggles once every `div`+1 system clocks, sixteen times in all. It then rests at the idle level.
- R5: Bits are taken from `sdin` on rising serial clock edges, MSB first. The first bit sampled ends up in `rx_data[7]`.
- R6: In master mode, a byte triggered at clock edge E0 completes at edge E0 + 16·(`div`+1). That is the 8th falling edge when `pol_neg` = 0 and the 8th rising edge when `pol_neg` = 1. `rx_data` changes only at completion.
- R7: In slave mode, `sclk_in` and `sdin` pass through a two-flop synchronizer. `done` rises three system clocks after the sixteenth external edge. External edges that arrive while `busy` is 0 have no effect.
- R8: `done` is set at completion and stays set until a `clr_done` pulse clears it.
- R9: `irq` is 1 exactly when `done` and `irq_en` are both 1.
- R10: A `trig` pulse while `busy` is 1 is ignored, so the byte in flight completes at its original time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; 0 holds the receiver idle |
| master | input | 1 | 1 = generate serial clock, 0 = follow external clock |
| pol_neg | input | 1 | Serial clock idle level (0 low, 1 high) |
| div | input | 8 | Master clock half-period minus one, in system clocks |
| trig | input | 1 | One-cycle pulse that starts a byte |
| clr_done | input | 1 | One-cycle pulse that clears `done` |
| irq_en | input | 1 | Interrupt enable |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sdin | input | 1 | Serial data input |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| rx_data | output | 8 | Receive buffer |
| done | output | 1 | Sticky receive-complete flag |
| busy | output | 1 | Byte in progress |
| irq | output | 1 | Interrupt request |

## Verification
In master mode, `busy` is due one edge after the trigger and `done` at exactly 16·(`div`+1) edges after that. The bench samples `done` one cycle early, where it must still be 0, and then on the due cycle. In slave mode the result is due three system clocks after the last external edge because of the synchronizer and edge-detect flops, and the bench checks both the second and third cycle. All samples are taken on the falling system clock edge, and inputs change there too. The feeder for master-mode data updates `sdin` only after each rising `sclk_out` has been sampled.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    localparam int unsigned RX_BITS  = 8;
    localparam int unsigned RX_EDGES = 2 * RX_BITS;
    localparam int unsigned EDGE_CW  = $clog2(RX_EDGES);

    typedef struct packed {
        logic               busy;
        logic [EDGE_CW-1:0] ecnt;
        logic [RX_BITS-1:0] shreg;
        logic [RX_BITS-1:0] rbuf;
        logic               done;
    } rx_state_t;
endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:1] q_hi,
    output logic         rise,
    output logic         fall
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;
    logic                     prev_d, prev_q;

    always_comb begin
        st_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
        prev_d = st_q[STAGES-1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            prev_q <= prev_d;
        end
    end

    assign q_hi = st_q[STAGES-1][W-1:1];
    assign rise = st_q[STAGES-1][0] & ~prev_q;
    assign fall = ~st_q[STAGES-1][0] & prev_q;
endmodule

// File: rtl/sync_rx_clkgen.sv
module sync_rx_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             idle_lvl,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             tick,
    output logic             rise
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } cg_t;

    cg_t d, q;

    always_comb begin
        d    = q;
        tick = run && (q.cnt == div);
        rise = tick && !q.sclk;
        if (!run) begin
            d.cnt  = '0;
            d.sclk = idle_lvl;
        end else if (tick) begin
            d.cnt  = '0;
            d.sclk = ~q.sclk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk = q.sclk;

    // R4
    toggle_on_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (q.sclk != $past(q.sclk))) |-> ($past(q.cnt) == $past(div)));
endmodule

// File: rtl/sync_rx.sv
module sync_rx
    import sync_rx_pkg::*;
#(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               master,
    input  logic               pol_neg,
    input  logic [DIV_W-1:0]   div,
    input  logic               trig,
    input  logic               clr_done,
    input  logic               irq_en,
    input  logic               sclk_in,
    input  logic               sdin,
    output logic               sclk_out,
    output logic               sclk_oe,
    output logic [RX_BITS-1:0] rx_data,
    output logic               done,
    output logic               busy,
    output logic               irq
);
    localparam logic [EDGE_CW-1:0] LAST_EDGE = EDGE_CW'(RX_EDGES - 1);

    rx_state_t d, q;

    logic sd_sync, s_rise, s_fall;
    logic cg_sclk, cg_tick, cg_rise;
    logic edge_ev, rise_ev, din, fin;

    sync_rx_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({sdin, sclk_in}),
        .q_hi (sd_sync),
        .rise (s_rise),
        .fall (s_fall)
    );

    sync_rx_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.busy & master),
        .idle_lvl(pol_neg),
        .div     (div),
        .sclk    (cg_sclk),
        .tick    (cg_tick),
        .rise    (cg_rise)
    );

    always_comb begin
        edge_ev = q.busy && (master ? cg_tick : (s_rise | s_fall));
        rise_ev = master ? cg_rise : s_rise;
        din     = master ? sdin : sd_sync;
        fin     = rx_en && edge_ev && (q.ecnt == LAST_EDGE);

        d = q;
        if (!rx_en) begin
            d.busy  = 1'b0;
            d.ecnt  = '0;
            d.shreg = '0;
        end else if (!q.busy) begin
            if (trig) begin
                d.busy = 1'b1;
                d.ecnt = '0;
            end
        end else if (edge_ev) begin
            if (rise_ev) d.shreg = {q.shreg[RX_BITS-2:0], din};
            if (fin) begin
                d.rbuf = d.shreg;
                d.busy = 1'b0;
                d.ecnt = '0;
            end else begin
                d.ecnt = q.ecnt + 1'b1;
            end
        end

        if (fin)           d.done = 1'b1;
        else if (clr_done) d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_out = cg_sclk;
    assign sclk_oe  = master;
    assign rx_data  = q.rbuf;
    assign done     = q.done;
    assign busy     = q.busy;
    assign irq      = q.done & irq_en;

    // R1
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !busy);

    // R10
    retrig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && rx_en && trig && !edge_ev) |=> (q.ecnt == $past(q.ecnt)));

    // R6
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(q.rbuf));

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(q.busy));
endmodule

// File: tb/test_sync_rx.sv
module test_sync_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, master = 1'b0, pol_neg = 1'b0;
    logic [7:0] div = 8'd0;
    logic       trig = 1'b0, clr_done = 1'b0, irq_en = 1'b0;
    logic       sclk_in = 1'b0, sdin = 1'b0;
    logic       sclk_out, sclk_oe, done, busy, irq;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sync_rx i_sync_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .master(master),
        .pol_neg(pol_neg), .div(div), .trig(trig), .clr_done(clr_done),
        .irq_en(irq_en), .sclk_in(sclk_in), .sdin(sdin),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rx_data(rx_data),
        .done(done), .busy(busy), .irq(irq)
    );

    // [17] master, [16] pol_neg, [15:8] div, [7:0] byte
    localparam logic [17:0] VEC [0:6] = '{
        {1'b1, 1'b0, 8'd0, 8'hA5},
        {1'b1, 1'b1, 8'd3, 8'h3C},
        {1'b1, 1'b0, 8'd1, 8'h81},
        {1'b0, 1'b0, 8'd0, 8'h5A},
        {1'b0, 1'b1, 8'd0, 8'hC3},
        {1'b1, 1'b1, 8'd0, 8'hFF},
        {1'b0, 1'b0, 8'd0, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        step(1);
        trig = 1'b0;
    endtask

    task automatic feed_master(input logic [7:0] b);
        for (int k = 1; k < 8; k++) begin
            @(posedge sclk_out);
            #1 sdin = b[7-k];
        end
    endtask

    task automatic master_byte(input logic [7:0] b, input int dv);
        int n;
        n = 16 * (dv + 1);
        sdin = b[7];
        pulse_trig();
        chk("R3 busy after trigger", busy, 1);
        fork
            feed_master(b);
            begin
                step(n - 1);
                chk("R6 done not early", done, 0);
                step(1);
                chk("R6 done on time", done, 1);
                chk("R3 busy cleared", busy, 0);
            end
        join
    endtask

    task automatic slave_edges(input logic [7:0] b, input logic final_chk);
        for (int e = 0; e < 16; e++) begin
            sdin = b[7 - e/2];
            step(4);
            sclk_in = ~sclk_in;
            if (e == 15 && final_chk) begin
                step(2);
                chk("R7 done not early", done, 0);
                step(1);
                chk("R7 done after sync", done, 1);
            end else begin
                step(4);
            end
        end
        step(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        chk("R1 reset busy", busy, 0);
        chk("R8 reset done", done, 0);
        chk("R5 reset data", rx_data, 0);
        chk("R9 reset irq", irq, 0);
        chk("R4 reset sclk idle", sclk_out, 0);

        // R2: trigger ignored while disabled
        master = 1'b1;
        pulse_trig();
        chk("R2 trig ignored when disabled", busy, 0);
        rx_en = 1'b1;
        step(50);
        chk("R2 no clock while armed", sclk_out, 0);
        chk("R2 still idle", busy, 0);

        // vector table
        for (int i = 0; i < 7; i++) begin
            master  = VEC[i][17];
            pol_neg = VEC[i][16];
            div     = VEC[i][15:8];
            irq_en  = i[0];
            sclk_in = VEC[i][16];
            step(6);
            chk("R4 oe follows mode", sclk_oe, VEC[i][17]);
            chk("R4 idle level", sclk_out, VEC[i][16]);
            if (VEC[i][17]) begin
                master_byte(VEC[i][7:0], int'(VEC[i][15:8]));
            end else begin
                pulse_trig();
                chk("R3 slave busy", busy, 1);
                slave_edges(VEC[i][7:0], 1'b1);
            end
            chk("R5 received byte", rx_data, VEC[i][7:0]);
            chk("R4 clock back idle", sclk_out, VEC[i][16]);
            chk("R9 irq follows enable", irq, i[0]);
            if (i == 0) begin
                step(20);
                chk("R8 done sticky", done, 1);
            end
            clr_done = 1'b1;
            step(1);
            clr_done = 1'b0;
            chk("R8 done cleared", done, 0);
            chk("R9 irq cleared", irq, 0);
        end

        // R7: external edges ignored with no trigger
        master = 1'b0; pol_neg = 1'b0; sclk_in = 1'b0;
        step(6);
        slave_edges(8'hE7, 1'b0);
        chk("R7 untriggered edges ignored done", done, 0);
        chk("R7 untriggered edges ignored data", rx_data, 8'h00);
        chk("R7 untriggered busy", busy, 0);

        // R10: retrigger during byte ignored
        master = 1'b1; pol_neg = 1'b0; div = 8'd1;
        step(6);
        sdin = 1'b0;
        pulse_trig();
        fork
            feed_master(8'h69);
            begin
                step(9);
                pulse_trig();
                step(31 - 10);
                chk("R10 no early completion", done, 0);
                step(1);
                chk("R10 original completion time", done, 1);
            end
        join
        chk("R10 byte intact", rx_data, 8'h69);
        clr_done = 1'b1; step(1); clr_done = 1'b0;

        // R1: abort mid-byte
        pulse_trig();
        step(20);
        rx_en = 1'b0;
        step(1);
        chk("R1 abort busy", busy, 0);
        step(100);
        chk("R1 abort no done", done, 0);
        chk("R1 abort clock idle", sclk_out, 0);
        chk("R1 abort buffer kept", rx_data, 8'h69);
        rx_en = 1'b1;
        step(2);
        master_byte(8'h96, 1);
        chk("R1 byte after abort", rx_data, 8'h96);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule